// File: doc/BRIEF.md
# In-Order Superscalar Issue Grouper

This block sits at the front of an execution pipeline and looks at a four-entry window of decoded instructions, slot 0 being the oldest. Every clock it picks the longest run of instructions, starting at slot 0, that can run together. A run ends at the first empty slot, at the first instruction that touches a register written earlier in the same run, or at the first instruction whose unit class is already used up. Instructions are never reordered. The chosen group then moves down the pipeline as one unit, so no later stage needs its own interlock.

From the same decision the block gives each slot a physical unit (two load/store units, two ALUs and two multiply-accumulate units). It also gives each of the six units a clock enable, which is high only when that unit has work in the group. Around the block, logic shifts the window by the issue count. A stall input forces an empty group so that the window is presented again unchanged.

Top module: `isg_issue_top`

## Requirements
- R1: The issued group is always slots 0..N-1 for some N from 0 to 4, and `issueCount` equals N. Grouping stops at the first slot whose valid bit is low, so an invalid slot 0 gives N = 0 and no later slot issues.
- R2: A slot ends the group if it reads (through an enabled source) or writes (through an enabled destination) a register specifier written by an enabled destination of an earlier slot. An earlier read followed by a later write is not a hazard. A disabled destination never conflicts.
- R3: A register specifier is 5 bits. Bit 4 selects the address domain (1) or the arithmetic domain (0), and bits 3:0 give the index. Two specifiers conflict only if all 5 bits are equal.
- R4: Class codes are 0 load/store, 1 ALU, 2 multiply-accumulate, 3 needs no unit. At most two slots of classes 0 to 2 each may be in one group. A third slot of the same class ends the group. Class 3 is never limited.
- R5: Within a class, the first issued slot gets unit 0 and the second gets unit 1. `slotUnit[3j+2:3j]` holds the unit id of slot j, which is class*2 + ordinal. The value 7 means the slot is not issued or needs no unit.
- R6: `unitClkEn` bit u (0 LS0, 1 LS1, 2 ALU0, 3 ALU1, 4 MAC0, 5 MAC1) is high only if unit u is assigned to a slot of the issued group.
- R7: While `stallIn` is high, the result is an empty group: count 0, all clock enables low and every slot unit 7.
- R8: Outputs are registered. They show the window and stall sampled at the previous rising clock edge. An active-low asynchronous reset clears them at once to count 0, enables 0 and every slot unit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stallIn | input | 1 | Forces an empty group this cycle |
| slotValid | input | 4 | Valid bit per window slot |
| slotClass | input | 8 | Unit class of slot j at [2j+1:2j] |
| slotDstEn | input | 4 | Destination enable per slot |
| slotDst | input | 20 | Destination specifier of slot j at [5j+4:5j] |
| slotSrcEn | input | 8 | Source enable k of slot j at bit 2j+k |
| slotSrc | input | 40 | Source k of slot j at [(2j+k)*5+4:(2j+k)*5] |
| issueCount | output | 3 | Number of slots issued |
| slotUnit | output | 12 | Assigned unit id per slot, 7 for none |
| unitClkEn | output | 6 | Per-unit clock enable |

## Verification
The assertions assume the window keeps to the documented encodings. They treat class 3 as a legal slot that needs no unit, and they do not assume the valid bits are contiguous. Given that, they check three relations: each unit's clock enable stays within the issue count, unit 1 of a class is never enabled without unit 0, and a stall or an empty head slot yields an empty group on the next edge. Every vector in the bench drives all fields of all four slots to defined values, including the specifiers of invalid slots, and applies them half a cycle away from the sampling edge, so no assertion ever sees an undefined input.

// File: rtl/isg_pkg.sv
`timescale 1ns/1ps
package isg_pkg;
  localparam int WIN_SLOTS       = 4;
  localparam int REG_IDX_W       = 4;
  localparam int SPEC_W          = REG_IDX_W + 1;  // domain bit on top
  localparam int SRCS_PER_SLOT   = 2;
  localparam int CLS_W           = 2;
  localparam int NUM_CLASSES     = 3;
  localparam int UNITS_PER_CLASS = 2;
  localparam int NUM_UNITS       = NUM_CLASSES * UNITS_PER_CLASS;
  localparam int UNIT_ID_W       = $clog2(NUM_UNITS + 1);
  localparam int CNT_W           = $clog2(WIN_SLOTS + 1);
  localparam int ORD_W           = $clog2(UNITS_PER_CLASS + 1);

  localparam logic [UNIT_ID_W-1:0] UNIT_NONE = '1;
  localparam logic [ORD_W-1:0]     ORD_CAP   = ORD_W'(UNITS_PER_CLASS);

  typedef enum logic [CLS_W-1:0] {
    CLS_MEM  = 2'd0,
    CLS_ALU  = 2'd1,
    CLS_MAC  = 2'd2,
    CLS_FREE = 2'd3
  } unitClass_e;

  // control -> datapath strobes
  typedef struct packed {
    logic                 quiet;
    logic [WIN_SLOTS-1:0] grant;
    logic [CNT_W-1:0]     count;
  } issueStrobe_t;
endpackage

// File: rtl/isg_depmatrix.sv
`timescale 1ns/1ps
module isg_depmatrix
  import isg_pkg::*;
(
  input  logic [WIN_SLOTS-1:0]                      dstEn,
  input  logic [WIN_SLOTS*SPEC_W-1:0]               dst,
  input  logic [WIN_SLOTS*SRCS_PER_SLOT-1:0]        srcEn,
  input  logic [WIN_SLOTS*SRCS_PER_SLOT*SPEC_W-1:0] src,
  output logic [WIN_SLOTS*WIN_SLOTS-1:0]            depOn  // bit j*W+i: slot j needs slot i
);
  for (genvar j = 0; j < WIN_SLOTS; j++) begin : g_young
    for (genvar i = 0; i < WIN_SLOTS; i++) begin : g_old
      if (i < j) begin : g_pair
        logic [SRCS_PER_SLOT-1:0] readHit;
        logic                     writeHit;
        for (genvar k = 0; k < SRCS_PER_SLOT; k++) begin : g_src
          // full specifier compare: domain bit keeps address and data apart (R3)
          assign readHit[k] = srcEn[j*SRCS_PER_SLOT+k] &&
            (src[(j*SRCS_PER_SLOT+k)*SPEC_W +: SPEC_W] == dst[i*SPEC_W +: SPEC_W]);
        end
        assign writeHit = dstEn[j] && (dst[j*SPEC_W +: SPEC_W] == dst[i*SPEC_W +: SPEC_W]);
        assign depOn[j*WIN_SLOTS+i] = dstEn[i] && ((|readHit) || writeHit);
      end else begin : g_none
        assign depOn[j*WIN_SLOTS+i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/isg_ctl.sv
`timescale 1ns/1ps
module isg_ctl
  import isg_pkg::*;
(
  input  logic                           stall,
  input  logic [WIN_SLOTS-1:0]           valid,
  input  logic [WIN_SLOTS*CLS_W-1:0]     cls,
  input  logic [WIN_SLOTS*WIN_SLOTS-1:0] depOn,
  output issueStrobe_t                   strobe
);
  logic             open;
  logic             room;
  unitClass_e       cur;
  logic [CNT_W-1:0] n;
  logic [ORD_W-1:0] used [2**CLS_W];

  always_comb begin
    open = !stall;
    n    = '0;
    room = 1'b0;
    cur  = CLS_FREE;
    strobe.grant = '0;
    for (int c = 0; c < 2**CLS_W; c++) used[c] = '0;
    for (int j = 0; j < WIN_SLOTS; j++) begin
      cur  = unitClass_e'(cls[j*CLS_W +: CLS_W]);
      room = (cur == CLS_FREE) || (used[cur] < ORD_CAP);
      // prefix closes at first invalid, dependent or oversubscribed slot
      open = open && valid[j] && !(|depOn[j*WIN_SLOTS +: WIN_SLOTS]) && room;
      strobe.grant[j] = open;
      if (open) begin
        n = n + 1'b1;
        if (cur != CLS_FREE) used[cur] = used[cur] + 1'b1;
      end
    end
    strobe.count = n;
    strobe.quiet = stall;
  end
endmodule

// File: rtl/isg_outreg.sv
`timescale 1ns/1ps
module isg_outreg
  import isg_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [WIN_SLOTS*CLS_W-1:0]     cls,
  input  issueStrobe_t                   strobe,
  output logic [CNT_W-1:0]               issueCount,
  output logic [WIN_SLOTS*UNIT_ID_W-1:0] slotUnit,
  output logic [NUM_UNITS-1:0]           unitClkEn
);
  unitClass_e                     cur;
  logic [UNIT_ID_W-1:0]           id;
  logic [ORD_W-1:0]               seen [2**CLS_W];
  logic [WIN_SLOTS*UNIT_ID_W-1:0] unitNext;
  logic [NUM_UNITS-1:0]           gateNext;

  always_comb begin
    unitNext = '1;
    gateNext = '0;
    cur = CLS_FREE;
    id  = UNIT_NONE;
    for (int c = 0; c < 2**CLS_W; c++) seen[c] = '0;
    for (int j = 0; j < WIN_SLOTS; j++) begin
      cur = unitClass_e'(cls[j*CLS_W +: CLS_W]);
      id  = UNIT_ID_W'(cur) * UNIT_ID_W'(UNITS_PER_CLASS) + UNIT_ID_W'(seen[cur]);
      if (strobe.grant[j] && cur != CLS_FREE) begin
        unitNext[j*UNIT_ID_W +: UNIT_ID_W] = id;
        gateNext[id] = 1'b1;
        seen[cur] = seen[cur] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issueCount <= '0;
      slotUnit   <= '1;
      unitClkEn  <= '0;
    end else begin
      issueCount <= strobe.count;
      slotUnit   <= unitNext;
      unitClkEn  <= gateNext;
    end
  end

  // R6: never more gated-on units than issued slots
  p_gates_fit_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(unitClkEn) <= int'(issueCount));

  // R7: a stall yields an empty, fully gated group
  p_quiet_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.quiet |=> (issueCount == '0 && unitClkEn == '0 && slotUnit == '1));

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_order
    // R5: second unit of a class only alongside the first
    p_unit_order_r5: assert property (@(posedge clk) disable iff (!rstN)
      unitClkEn[c*UNITS_PER_CLASS+1] |-> unitClkEn[c*UNITS_PER_CLASS]);
  end
endmodule

// File: rtl/isg_issue_top.sv
`timescale 1ns/1ps
module isg_issue_top
  import isg_pkg::*;
(
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      stallIn,
  input  logic [WIN_SLOTS-1:0]                      slotValid,
  input  logic [WIN_SLOTS*CLS_W-1:0]                slotClass,
  input  logic [WIN_SLOTS-1:0]                      slotDstEn,
  input  logic [WIN_SLOTS*SPEC_W-1:0]               slotDst,
  input  logic [WIN_SLOTS*SRCS_PER_SLOT-1:0]        slotSrcEn,
  input  logic [WIN_SLOTS*SRCS_PER_SLOT*SPEC_W-1:0] slotSrc,
  output logic [CNT_W-1:0]                          issueCount,
  output logic [WIN_SLOTS*UNIT_ID_W-1:0]            slotUnit,
  output logic [NUM_UNITS-1:0]                      unitClkEn
);
  logic [WIN_SLOTS*WIN_SLOTS-1:0] depOn;
  issueStrobe_t                   strobe;

  isg_depmatrix u_dep (
    .dstEn(slotDstEn), .dst(slotDst), .srcEn(slotSrcEn), .src(slotSrc), .depOn(depOn)
  );

  isg_ctl u_ctl (
    .stall(stallIn), .valid(slotValid), .cls(slotClass), .depOn(depOn), .strobe(strobe)
  );

  isg_outreg u_out (
    .clk(clk), .rstN(rstN), .cls(slotClass), .strobe(strobe),
    .issueCount(issueCount), .slotUnit(slotUnit), .unitClkEn(unitClkEn)
  );

  // R1: an empty head slot means nothing issues
  p_idle_head_r1: assert property (@(posedge clk) disable iff (!rstN)
    !slotValid[0] |=> (issueCount == '0 && unitClkEn == '0));
endmodule

// File: tb/isg_issue_top_tb.sv
`timescale 1ns/1ps
module isg_issue_top_tb;
  typedef struct packed {
    logic       v;
    logic [1:0] cls;
    logic       de;
    logic [4:0] d;
    logic [1:0] se;
    logic [4:0] s1;
    logic [4:0] s0;
  } ins_t;

  typedef struct packed {
    logic          stall;
    ins_t [3:0]    w;
    logic [2:0]    cnt;
    logic [11:0]   units;
    logic [5:0]    gate;
    logic [3:0]    req;
  } vec_t;

  localparam ins_t INV = '0;
  localparam int NV = 12;
  // units = {slot3, slot2, slot1, slot0}; gate bits {MAC1,MAC0,ALU1,ALU0,LS1,LS0}
  localparam vec_t TAB [NV] = '{
    // R1: four independent, full group
    '{1'b0, '{'{1'b1,2'd1,1'b1,5'h04,2'b00,5'h00,5'h00}, '{1'b1,2'd0,1'b1,5'h03,2'b00,5'h00,5'h00},
              '{1'b1,2'd2,1'b1,5'h02,2'b00,5'h00,5'h00}, '{1'b1,2'd1,1'b1,5'h01,2'b00,5'h00,5'h00}},
      3'd4, {3'd3,3'd0,3'd4,3'd2}, 6'b011101, 4'd1},
    // R2: read after write ends group
    '{1'b0, '{INV, INV, '{1'b1,2'd1,1'b1,5'h05,2'b01,5'h00,5'h01}, '{1'b1,2'd1,1'b1,5'h01,2'b00,5'h00,5'h00}},
      3'd1, {3'd7,3'd7,3'd7,3'd2}, 6'b000100, 4'd2},
    // R2: write after write ends group
    '{1'b0, '{INV, '{1'b1,2'd0,1'b1,5'h01,2'b00,5'h00,5'h00}, '{1'b1,2'd2,1'b1,5'h02,2'b00,5'h00,5'h00},
              '{1'b1,2'd1,1'b1,5'h01,2'b00,5'h00,5'h00}},
      3'd2, {3'd7,3'd7,3'd4,3'd2}, 6'b010100, 4'd2},
    // R3: address reg 1 vs data reg 1 independent, address reg 1 reread conflicts
    '{1'b0, '{INV, '{1'b1,2'd0,1'b1,5'h12,2'b01,5'h00,5'h11}, '{1'b1,2'd1,1'b1,5'h02,2'b01,5'h00,5'h01},
              '{1'b1,2'd0,1'b1,5'h11,2'b00,5'h00,5'h00}},
      3'd2, {3'd7,3'd7,3'd2,3'd0}, 6'b000101, 4'd3},
    // R4: third ALU ends group; later free LS not issued (R1)
    '{1'b0, '{'{1'b1,2'd0,1'b1,5'h04,2'b00,5'h00,5'h00}, '{1'b1,2'd1,1'b1,5'h03,2'b00,5'h00,5'h00},
              '{1'b1,2'd1,1'b1,5'h02,2'b00,5'h00,5'h00}, '{1'b1,2'd1,1'b1,5'h01,2'b00,5'h00,5'h00}},
      3'd2, {3'd7,3'd7,3'd3,3'd2}, 6'b001100, 4'd4},
    // R1: invalid head slot
    '{1'b0, '{'{1'b1,2'd1,1'b1,5'h03,2'b00,5'h00,5'h00}, '{1'b1,2'd1,1'b1,5'h02,2'b00,5'h00,5'h00},
              '{1'b1,2'd1,1'b1,5'h01,2'b00,5'h00,5'h00}, INV},
      3'd0, {3'd7,3'd7,3'd7,3'd7}, 6'b000000, 4'd1},
    // R1: invalid middle slot
    '{1'b0, '{INV, '{1'b1,2'd2,1'b1,5'h02,2'b00,5'h00,5'h00}, INV, '{1'b1,2'd2,1'b1,5'h01,2'b00,5'h00,5'h00}},
      3'd1, {3'd7,3'd7,3'd7,3'd4}, 6'b010000, 4'd1},
    // R4: class 3 needs no unit and is never limited
    '{1'b0, '{'{1'b1,2'd0,1'b1,5'h01,2'b00,5'h00,5'h00}, '{1'b1,2'd3,1'b0,5'h00,2'b00,5'h00,5'h00},
              '{1'b1,2'd3,1'b0,5'h00,2'b00,5'h00,5'h00}, '{1'b1,2'd3,1'b0,5'h00,2'b00,5'h00,5'h00}},
      3'd4, {3'd0,3'd7,3'd7,3'd7}, 6'b000001, 4'd4},
    // R5: in-order unit assignment within classes
    '{1'b0, '{'{1'b1,2'd0,1'b1,5'h04,2'b00,5'h00,5'h00}, '{1'b1,2'd2,1'b1,5'h03,2'b00,5'h00,5'h00},
              '{1'b1,2'd0,1'b1,5'h02,2'b00,5'h00,5'h00}, '{1'b1,2'd2,1'b1,5'h01,2'b00,5'h00,5'h00}},
      3'd4, {3'd1,3'd5,3'd0,3'd4}, 6'b110011, 4'd5},
    // R7: stall over a full window
    '{1'b1, '{'{1'b1,2'd1,1'b1,5'h04,2'b00,5'h00,5'h00}, '{1'b1,2'd0,1'b1,5'h03,2'b00,5'h00,5'h00},
              '{1'b1,2'd2,1'b1,5'h02,2'b00,5'h00,5'h00}, '{1'b1,2'd1,1'b1,5'h01,2'b00,5'h00,5'h00}},
      3'd0, {3'd7,3'd7,3'd7,3'd7}, 6'b000000, 4'd7},
    // R2: write after read is fine; disabled dest never conflicts
    '{1'b0, '{INV, '{1'b1,2'd2,1'b0,5'h01,2'b00,5'h00,5'h00}, '{1'b1,2'd1,1'b1,5'h03,2'b00,5'h00,5'h00},
              '{1'b1,2'd1,1'b1,5'h01,2'b01,5'h00,5'h03}},
      3'd3, {3'd7,3'd4,3'd3,3'd2}, 6'b011100, 4'd2},
    // R6: single slot reading its own dest; only ALU0 gated on
    '{1'b0, '{INV, INV, INV, '{1'b1,2'd1,1'b1,5'h01,2'b11,5'h01,5'h01}},
      3'd1, {3'd7,3'd7,3'd7,3'd2}, 6'b000100, 4'd6}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stallIn = 1'b0;
  logic [3:0]  slotValid = '0;
  logic [7:0]  slotClass = '0;
  logic [3:0]  slotDstEn = '0;
  logic [19:0] slotDst = '0;
  logic [7:0]  slotSrcEn = '0;
  logic [39:0] slotSrc = '0;
  logic [2:0]  issueCount;
  logic [11:0] slotUnit;
  logic [5:0]  unitClkEn;
  int nChecks = 0;
  int nErrs = 0;

  always #2.5 clk = ~clk;

  isg_issue_top u_dut (
    .clk(clk), .rstN(rstN), .stallIn(stallIn), .slotValid(slotValid), .slotClass(slotClass),
    .slotDstEn(slotDstEn), .slotDst(slotDst), .slotSrcEn(slotSrcEn), .slotSrc(slotSrc),
    .issueCount(issueCount), .slotUnit(slotUnit), .unitClkEn(unitClkEn)
  );

  task automatic drive(input vec_t t);
    stallIn = t.stall;
    for (int j = 0; j < 4; j++) begin
      slotValid[j]         = t.w[j].v;
      slotClass[2*j +: 2]  = t.w[j].cls;
      slotDstEn[j]         = t.w[j].de;
      slotDst[5*j +: 5]    = t.w[j].d;
      slotSrcEn[2*j +: 2]  = t.w[j].se;
      slotSrc[10*j +: 5]   = t.w[j].s0;
      slotSrc[10*j+5 +: 5] = t.w[j].s1;
    end
  endtask

  task automatic check(input string tag, input logic [2:0] eC, input logic [11:0] eU,
                       input logic [5:0] eG);
    nChecks++;
    if (issueCount !== eC || slotUnit !== eU || unitClkEn !== eG) begin
      nErrs++;
      $display("FAIL %s: count=%0d units=%h gate=%b expected count=%0d units=%h gate=%b",
               tag, issueCount, slotUnit, unitClkEn, eC, eU, eG);
    end
  endtask

  initial begin
    #(5.0 * 20000);
    nErrs++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset state", 3'd0, 12'hfff, 6'b0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      drive(TAB[v]);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", TAB[v].req, v), TAB[v].cnt, TAB[v].units, TAB[v].gate);
    end

    // R8: outputs change only at the clock edge
    drive(TAB[0]);
    @(posedge clk); @(negedge clk);
    drive(TAB[1]);
    #1;
    check("R8 hold before edge", TAB[0].cnt, TAB[0].units, TAB[0].gate);
    @(posedge clk); @(negedge clk);
    check("R8 update after edge", TAB[1].cnt, TAB[1].units, TAB[1].gate);

    // R7: sustained stall then release presents the same window again
    drive(TAB[9]);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R7 stall second cycle", 3'd0, 12'hfff, 6'b0);
    stallIn = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 release issues window", TAB[0].cnt, TAB[0].units, TAB[0].gate);

    // R8: asynchronous reset clears without a clock edge
    #1 rstN = 1'b0;
    #0.5;
    check("R8 async reset", 3'd0, 12'hfff, 6'b0);
    @(negedge clk);
    rstN = 1'b1;
    drive(TAB[8]);
    @(posedge clk); @(negedge clk);
    check("R5 after reset", TAB[8].cnt, TAB[8].units, TAB[8].gate);

    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end
endmodule